// File: doc/BRIEF.md
# Dual-Mode 64-Bit Lane Scrambler and Descrambler

This block whitens one serial lane 64 bits per clock with the x^58 + x^39 + 1 polynomial. It has a transmit path that scrambles and a receive path that descrambles. Both paths share one mode pin. In self-synchronous mode, the scrambler feeds its own output bits back into its 58-bit history. The descrambler feeds the received bits back into its history, so it locks to any transmitter once 58 bits have passed. In seeded mode, each path runs a free-running generator that starts from a per-lane 15-bit seed. The generator's keystream is XORed onto the data, and the generator moves on by 64 steps for every word, whatever the data holds. Each path can be bypassed on its own. A flag on the receive side reports a seeded generator whose state has collapsed to all zeros.

Words enter and leave each path on valid/ready streams that have one register stage. A word is taken when `*_in_valid` and `*_in_ready` are both high at a clock edge. The result shows on `*_out_data` with `*_out_valid` high from that edge on. `*_in_ready` is high when the output register is empty or is being drained in the same cycle (`*_out_ready` high). There is therefore a combinational path from `*_out_ready` to `*_in_ready`. While `*_out_valid` is high and `*_out_ready` is low, the output word is held unchanged and no new word is taken. The state advances only on words that are taken. The mode, bypass and seed pins are plain control pins, sampled at each edge.

Top module: `lane_scrambler`

## Requirements
- R1: In self-synchronous mode, the transmit path handles bits 0 to 63 in that order within one cycle. Each output bit is the input bit XOR history[38] XOR history[57]. That output bit is then shifted into history[0], and the older bits move up one place.
- R2: In self-synchronous mode, the receive path uses the same output equation as R1, but shifts the received input bit into history[0] instead of the output bit.
- R3: In seeded mode, each of the 64 steps makes a key bit k = history[38] XOR history[57]. The output bit is the input bit XOR k, and k is shifted into history[0]. The history therefore advances 64 steps per accepted word, independently of the data.
- R4: A synchronous reset (rst_n low at an edge) empties both output registers. It loads each history with the seed zero-extended to 58 bits (seed in bits 14:0) when mode_sync is 1, or with all zeros when mode_sync is 0.
- R5: In seeded mode, a high seed_load loads the zero-extended seed into both histories. A word accepted in the same cycle is already processed from the loaded seed.
- R6: In self-synchronous mode, seed_load and seed have no effect on either path's output.
- R7: When a path's bypass pin is high, a word accepted on that path leaves it unchanged, and that path's history does not advance. The other path is not affected.
- R8: rx_stuck_err is high whenever mode_sync is 1 and the receive history is all zeros, and low otherwise. A zero seed loaded in seeded mode therefore raises it. Words then pass through the receive path unchanged until a nonzero seed is loaded.
- R9: in_ready = !out_valid || out_ready on each path. A word accepted at an edge is on the output from that edge on. The output is held stable while it is stalled, and no word is lost or repeated.
- R10: A transmit output fed into the receive input reproduces the original words. In seeded mode, this holds when both paths were loaded from the same seed. In self-synchronous mode, it holds for every word after the first, whatever state the receive history started in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_sync | input | 1 | 1 = seeded mode, 0 = self-synchronous mode |
| seed | input | SEED_W | Per-lane generator seed |
| seed_load | input | 1 | Reload both histories from seed (seeded mode only) |
| tx_bypass | input | 1 | Transmit path passes data unchanged |
| rx_bypass | input | 1 | Receive path passes data unchanged |
| tx_in_data | input | DATA_W | Plain word to scramble |
| tx_in_valid | input | 1 | Transmit input word present |
| tx_in_ready | output | 1 | Transmit path can take a word |
| tx_out_data | output | DATA_W | Scrambled word |
| tx_out_valid | output | 1 | Scrambled word present |
| tx_out_ready | input | 1 | Consumer takes the scrambled word |
| rx_in_data | input | DATA_W | Received word to descramble |
| rx_in_valid | input | 1 | Receive input word present |
| rx_in_ready | output | 1 | Receive path can take a word |
| rx_out_data | output | DATA_W | Descrambled word |
| rx_out_valid | output | 1 | Descrambled word present |
| rx_out_ready | input | 1 | Consumer takes the descrambled word |
| rx_stuck_err | output | 1 | Seeded receive generator has all-zero state |

## Verification
A word accepted at an edge is due on its path's output from that same edge on. in_ready follows out_ready combinationally within the cycle. rx_stuck_err follows the edge that loads or advances the receive history, so a loopback word needs two edges from transmit input to receive output. The bench drives inputs at the falling edge and checks in_ready 1 ns later. It compares the outputs and the error flag with its reference model at the next falling edge, after the model has applied the previous edge. Every data output and flag is therefore checked exactly one edge after the stimulus that produced it.

// File: rtl/lane_scr_pkg.sv
package lane_scr_pkg;
  // History length and tap positions of x^58 + x^39 + 1
  localparam int unsigned HIST_W   = 58;
  localparam int unsigned TAP_NEAR = 39;
  localparam int unsigned TAP_FAR  = 58;

  typedef enum logic {
    MODE_SELF_SYNC = 1'b0,
    MODE_SEEDED    = 1'b1
  } scr_mode_e;
endpackage

// File: rtl/lane_scr_selfsync.sv
module lane_scr_selfsync #(
  parameter int unsigned DATA_W     = 64,
  parameter int unsigned HIST_W     = 58,
  parameter int unsigned TAP_NEAR   = 39,
  parameter int unsigned TAP_FAR    = 58,
  parameter bit          FEED_INPUT = 1'b0
) (
  input  logic [HIST_W-1:0] hist_i,
  input  logic [DATA_W-1:0] din_i,
  output logic [DATA_W-1:0] dout_o,
  output logic [HIST_W-1:0] hist_o
);
  logic [HIST_W-1:0] h;
  logic              fb;

  generate
    if (FEED_INPUT) begin : g_descramble
      // received bit enters the history
      always_comb begin
        h      = hist_i;
        fb     = 1'b0;
        dout_o = '0;
        for (int i = 0; i < int'(DATA_W); i++) begin
          fb        = h[TAP_NEAR-1] ^ h[TAP_FAR-1];
          dout_o[i] = din_i[i] ^ fb;
          h         = {h[HIST_W-2:0], din_i[i]};
        end
        hist_o = h;
      end
    end else begin : g_scramble
      // produced bit enters the history
      always_comb begin
        h      = hist_i;
        fb     = 1'b0;
        dout_o = '0;
        for (int i = 0; i < int'(DATA_W); i++) begin
          fb        = h[TAP_NEAR-1] ^ h[TAP_FAR-1];
          dout_o[i] = din_i[i] ^ fb;
          h         = {h[HIST_W-2:0], dout_o[i]};
        end
        hist_o = h;
      end
    end
  endgenerate
endmodule

// File: rtl/lane_scr_keygen.sv
module lane_scr_keygen #(
  parameter int unsigned DATA_W   = 64,
  parameter int unsigned HIST_W   = 58,
  parameter int unsigned TAP_NEAR = 39,
  parameter int unsigned TAP_FAR  = 58
) (
  input  logic [HIST_W-1:0] hist_i,
  output logic [DATA_W-1:0] key_o,
  output logic [HIST_W-1:0] hist_o
);
  logic [HIST_W-1:0] h;
  logic              k;

  // free-running generator: 64 steps, no data dependence
  always_comb begin
    h     = hist_i;
    k     = 1'b0;
    key_o = '0;
    for (int i = 0; i < int'(DATA_W); i++) begin
      k        = h[TAP_NEAR-1] ^ h[TAP_FAR-1];
      key_o[i] = k;
      h        = {h[HIST_W-2:0], k};
    end
    hist_o = h;
  end
endmodule

// File: rtl/lane_scr_path.sv
module lane_scr_path
  import lane_scr_pkg::*;
#(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned SEED_W = 15,
  parameter bit          IS_RX  = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_sync,
  input  logic              bypass,
  input  logic [SEED_W-1:0] seed,
  input  logic              seed_load,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              stuck_o
);
  localparam int unsigned PAD_W = HIST_W - SEED_W;

  scr_mode_e         mode;
  logic [HIST_W-1:0] seed_ext;
  logic [HIST_W-1:0] hist_q;
  logic [HIST_W-1:0] hist_cur;
  logic [HIST_W-1:0] hist_ss;
  logic [HIST_W-1:0] hist_key;
  logic [HIST_W-1:0] hist_nxt;
  logic [DATA_W-1:0] data_ss;
  logic [DATA_W-1:0] key;
  logic [DATA_W-1:0] data_res;
  logic              load_now;
  logic              accept;

  assign mode     = scr_mode_e'(mode_sync);
  assign seed_ext = {{PAD_W{1'b0}}, seed};
  assign load_now = (mode == MODE_SEEDED) && seed_load;
  assign hist_cur = load_now ? seed_ext : hist_q;
  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  lane_scr_selfsync #(
    .DATA_W(DATA_W), .HIST_W(HIST_W), .TAP_NEAR(TAP_NEAR), .TAP_FAR(TAP_FAR),
    .FEED_INPUT(IS_RX)
  ) i_selfsync (
    .hist_i(hist_cur), .din_i(in_data), .dout_o(data_ss), .hist_o(hist_ss)
  );

  lane_scr_keygen #(
    .DATA_W(DATA_W), .HIST_W(HIST_W), .TAP_NEAR(TAP_NEAR), .TAP_FAR(TAP_FAR)
  ) i_keygen (
    .hist_i(hist_cur), .key_o(key), .hist_o(hist_key)
  );

  always_comb begin
    if (bypass) begin
      data_res = in_data;
      hist_nxt = hist_cur;
    end else begin
      case (mode)
        MODE_SEEDED: begin
          data_res = in_data ^ key;
          hist_nxt = hist_key;
        end
        default: begin
          data_res = data_ss;
          hist_nxt = hist_ss;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist_q    <= (mode == MODE_SEEDED) ? seed_ext : '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      if (accept) begin
        hist_q    <= hist_nxt;
        out_data  <= data_res;
        out_valid <= 1'b1;
      end else begin
        hist_q <= hist_cur;
        if (out_ready) out_valid <= 1'b0;
      end
    end
  end

  assign stuck_o = (mode == MODE_SEEDED) && (hist_q == '0);

  // R9
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));
  // R9
  accept_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);
  // R7
  bypass_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && bypass && !load_now |=> $stable(hist_q));
  // R6
  selfsync_seed_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_sync && seed_load && !(in_valid && in_ready) |=> $stable(hist_q));
  // R5
  seed_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_sync && seed_load && !(in_valid && in_ready) |=> hist_q == $past(seed_ext));
  // R3
  seeded_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && mode_sync && !bypass && !seed_load && hist_q != '0
    |=> hist_q != $past(hist_q));
endmodule

// File: rtl/lane_scrambler.sv
module lane_scrambler
  import lane_scr_pkg::*;
#(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned SEED_W = 15,
  parameter bit          ERR_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_sync,
  input  logic [SEED_W-1:0] seed,
  input  logic              seed_load,
  input  logic              tx_bypass,
  input  logic              rx_bypass,
  input  logic [DATA_W-1:0] tx_in_data,
  input  logic              tx_in_valid,
  output logic              tx_in_ready,
  output logic [DATA_W-1:0] tx_out_data,
  output logic              tx_out_valid,
  input  logic              tx_out_ready,
  input  logic [DATA_W-1:0] rx_in_data,
  input  logic              rx_in_valid,
  output logic              rx_in_ready,
  output logic [DATA_W-1:0] rx_out_data,
  output logic              rx_out_valid,
  input  logic              rx_out_ready,
  output logic              rx_stuck_err
);
  logic tx_stuck_unused;
  logic rx_stuck;

  lane_scr_path #(.DATA_W(DATA_W), .SEED_W(SEED_W), .IS_RX(1'b0)) i_tx_path (
    .clk(clk), .rst_n(rst_n), .mode_sync(mode_sync), .bypass(tx_bypass),
    .seed(seed), .seed_load(seed_load),
    .in_data(tx_in_data), .in_valid(tx_in_valid), .in_ready(tx_in_ready),
    .out_data(tx_out_data), .out_valid(tx_out_valid), .out_ready(tx_out_ready),
    .stuck_o(tx_stuck_unused)
  );

  lane_scr_path #(.DATA_W(DATA_W), .SEED_W(SEED_W), .IS_RX(1'b1)) i_rx_path (
    .clk(clk), .rst_n(rst_n), .mode_sync(mode_sync), .bypass(rx_bypass),
    .seed(seed), .seed_load(seed_load),
    .in_data(rx_in_data), .in_valid(rx_in_valid), .in_ready(rx_in_ready),
    .out_data(rx_out_data), .out_valid(rx_out_valid), .out_ready(rx_out_ready),
    .stuck_o(rx_stuck)
  );

  generate
    if (ERR_EN) begin : g_err
      assign rx_stuck_err = rx_stuck;

      // R8
      stuck_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_stuck_err && !seed_load && rx_in_valid && rx_in_ready && !rx_bypass
        |=> rx_stuck_err || !mode_sync);
      // R8
      stuck_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_stuck_err && !seed_load && rx_in_valid && rx_in_ready
        |=> rx_out_data == $past(rx_in_data));
    end else begin : g_no_err
      logic err_unused;
      assign err_unused   = rx_stuck;
      assign rx_stuck_err = 1'b0;
    end
  endgenerate
endmodule

// File: tb/test_lane_scrambler.sv
`timescale 1ns/1ps
module test_lane_scrambler;
  localparam int DW = 64;
  localparam int KW = 15;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mode_sync = 1'b0;
  logic [KW-1:0] seed = '0;
  logic          seed_load = 1'b0;
  logic          tx_bypass = 1'b0, rx_bypass = 1'b0;
  logic [DW-1:0] tx_in_data = '0, rx_in_data = '0;
  logic          tx_in_valid = 1'b0, rx_in_valid = 1'b0;
  logic          tx_out_ready = 1'b0, rx_out_ready = 1'b0;
  logic          tx_in_ready, rx_in_ready, tx_out_valid, rx_out_valid, rx_stuck_err;
  logic [DW-1:0] tx_out_data, rx_out_data;

  always #2.5 clk = ~clk;

  lane_scrambler #(.DATA_W(DW), .SEED_W(KW), .ERR_EN(1'b1)) i_lane_scrambler (
    .clk(clk), .rst_n(rst_n), .mode_sync(mode_sync), .seed(seed), .seed_load(seed_load),
    .tx_bypass(tx_bypass), .rx_bypass(rx_bypass),
    .tx_in_data(tx_in_data), .tx_in_valid(tx_in_valid), .tx_in_ready(tx_in_ready),
    .tx_out_data(tx_out_data), .tx_out_valid(tx_out_valid), .tx_out_ready(tx_out_ready),
    .rx_in_data(rx_in_data), .rx_in_valid(rx_in_valid), .rx_in_ready(rx_in_ready),
    .rx_out_data(rx_out_data), .rx_out_valid(rx_out_valid), .rx_out_ready(rx_out_ready),
    .rx_stuck_err(rx_stuck_err)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  // reference model, index 0 = transmit, 1 = receive
  logic [57:0] m_st [2];
  logic        m_ov [2];
  logic [63:0] m_od [2];
  string       m_lab [2];
  bit          m_post_rst [2];

  // stimulus knobs
  int  p_valid = 0, p_ready = 100, p_load = 0;
  bit  byp_on = 0, rnd_seed = 0, force_load = 0, lb_on = 0;
  int  lb_skip = 0;
  bit  next_mode = 0;
  logic [KW-1:0] next_seed = '0;
  logic [63:0] lb_q [$];

  function automatic bit pct(int p);
    return ($urandom % 100) < p;
  endfunction

  function automatic logic [63:0] rnd_word();
    int kind = $urandom % 4;
    if (kind == 0) return 64'h0;
    if (kind == 1) return '1;
    return {$urandom, $urandom};
  endfunction

  // bitwise behaviour of R1/R2/R3, bit 0 first
  function automatic void model_word(input bit is_rx, input bit seeded, input logic [63:0] din,
                                     inout logic [57:0] st, output logic [63:0] dout);
    logic t, o;
    dout = '0;
    for (int i = 0; i < 64; i++) begin
      t = st[38] ^ st[57];
      o = din[i] ^ t;
      dout[i] = o;
      if (seeded)     st = {st[56:0], t};
      else if (is_rx) st = {st[56:0], din[i]};
      else            st = {st[56:0], o};
    end
  endfunction

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic model_edge();
    for (int p = 0; p < 2; p++) begin
      logic        vin  = p ? rx_in_valid : tx_in_valid;
      logic [63:0] din  = p ? rx_in_data  : tx_in_data;
      logic        ordy = p ? rx_out_ready : tx_out_ready;
      logic        byp  = p ? rx_bypass : tx_bypass;
      logic        ld   = mode_sync && seed_load;
      logic        acc  = vin && (!m_ov[p] || ordy);
      logic [57:0] cur  = ld ? {43'b0, seed} : m_st[p];
      logic [63:0] dout;
      if (acc) begin
        if (byp) dout = din;
        else model_word(p == 1, mode_sync, din, cur, dout);
        if (byp)                        m_lab[p] = "R7";
        else if (ld)                    m_lab[p] = "R5";
        else if (!mode_sync && seed_load) m_lab[p] = "R6";
        else if (m_post_rst[p])         m_lab[p] = "R4";
        else if (mode_sync)             m_lab[p] = "R3";
        else                            m_lab[p] = (p == 1) ? "R2" : "R1";
        m_od[p] = dout;
        m_ov[p] = 1'b1;
        m_post_rst[p] = 1'b0;
        if (lb_on && p == 0) lb_q.push_back(din);
      end else if (ordy) begin
        m_ov[p] = 1'b0;
      end
      m_st[p] = cur;
    end
  endtask

  task automatic step();
    logic [63:0] exp;
    @(negedge clk);
    check("R9", "tx_out_valid", 64'(tx_out_valid), 64'(m_ov[0]));
    if (m_ov[0]) check(m_lab[0], "tx_out_data", tx_out_data, m_od[0]);
    check("R9", "rx_out_valid", 64'(rx_out_valid), 64'(m_ov[1]));
    if (m_ov[1]) check(m_lab[1], "rx_out_data", rx_out_data, m_od[1]);
    check("R8", "rx_stuck_err", 64'(rx_stuck_err), 64'(mode_sync && (m_st[1] == '0)));
    if (lb_on && m_ov[1]) begin
      if (lb_q.size() == 0) check("R10", "loopback queue empty", 64'(1), 64'(0));
      else begin
        exp = lb_q.pop_front();
        if (lb_skip > 0) lb_skip--;
        else check("R10", "loopback word", rx_out_data, exp);
      end
    end
    mode_sync = next_mode;
    if (lb_on) begin
      tx_in_valid  = pct(p_valid);
      tx_in_data   = rnd_word();
      tx_out_ready = 1'b1;
      rx_in_valid  = tx_out_valid;
      rx_in_data   = tx_out_data;
      rx_out_ready = 1'b1;
      tx_bypass    = 1'b0;
      rx_bypass    = 1'b0;
      seed_load    = 1'b0;
    end else begin
      tx_in_valid  = pct(p_valid);
      rx_in_valid  = pct(p_valid);
      tx_in_data   = rnd_word();
      rx_in_data   = rnd_word();
      tx_out_ready = pct(p_ready);
      rx_out_ready = pct(p_ready);
      tx_bypass    = byp_on && pct(25);
      rx_bypass    = byp_on && pct(25);
      seed         = rnd_seed ? KW'($urandom) : next_seed;
      seed_load    = force_load || (p_load > 0 && pct(p_load));
      force_load   = 1'b0;
    end
    #1;
    check("R9", "tx_in_ready", 64'(tx_in_ready), 64'(!m_ov[0] || tx_out_ready));
    check("R9", "rx_in_ready", 64'(rx_in_ready), 64'(!m_ov[1] || rx_out_ready));
    model_edge();
  endtask

  task automatic do_reset();
    @(negedge clk);
    mode_sync = next_mode;
    seed = next_seed;
    rst_n = 1'b0;
    tx_in_valid = 1'b0; rx_in_valid = 1'b0; seed_load = 1'b0;
    tx_out_ready = 1'b0; rx_out_ready = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    for (int p = 0; p < 2; p++) begin
      m_st[p] = mode_sync ? {43'b0, seed} : 58'b0;
      m_ov[p] = 1'b0;
      m_od[p] = '0;
      m_lab[p] = "R4";
      m_post_rst[p] = 1'b1;
    end
    #1;
    check("R4", "tx_out_valid after reset", 64'(tx_out_valid), 64'(0));
    check("R4", "rx_out_valid after reset", 64'(rx_out_valid), 64'(0));
    check("R4", "tx_in_ready after reset", 64'(tx_in_ready), 64'(1));
    check("R4", "rx_in_ready after reset", 64'(rx_in_ready), 64'(1));
    check("R4", "rx_stuck_err after reset", 64'(rx_stuck_err),
          64'(mode_sync && seed == '0));
  endtask

  task automatic traffic(int n, int pv, int pr, int pl);
    p_valid = pv; p_ready = pr; p_load = pl;
    repeat (n) step();
  endtask

  task automatic idle(int n);
    byp_on = 0; rnd_seed = 0;
    traffic(n, 0, 100, 0);
  endtask

  initial begin
    // self-synchronous, random flow, seed_load toggling (R1 R2 R6 R9)
    next_mode = 0; next_seed = 15'h1234;
    do_reset();
    rnd_seed = 1;
    traffic(200, 70, 70, 15);
    byp_on = 1;
    traffic(150, 70, 60, 10);
    idle(3);

    // seeded mode (R3 R5 R7)
    next_mode = 1; next_seed = 15'h2a5c; force_load = 1;
    idle(2);
    rnd_seed = 1; byp_on = 0;
    traffic(200, 75, 70, 5);
    byp_on = 1;
    traffic(100, 70, 70, 5);
    idle(2);

    // zero seed: stuck generator (R8)
    next_seed = 15'h0; force_load = 1;
    idle(2);
    traffic(60, 80, 80, 0);
    next_seed = 15'h0001; force_load = 1;
    idle(2);
    traffic(40, 80, 80, 0);

    // reset while seeded (R4)
    next_seed = 15'h7ffe;
    do_reset();
    traffic(100, 70, 70, 0);
    idle(3);

    // seeded loopback (R10)
    next_seed = 15'h3c81; force_load = 1;
    idle(2);
    lb_on = 1; lb_skip = 0;
    traffic(150, 80, 100, 0);
    traffic(4, 0, 100, 0);
    lb_on = 0;
    check("R10", "seeded loopback drained", 64'(lb_q.size()), 64'(0));

    // self-synchronous loopback from unrelated receive state (R10)
    next_mode = 0;
    traffic(30, 80, 100, 0);
    idle(3);
    lb_on = 1; lb_skip = 1;
    traffic(150, 80, 100, 0);
    traffic(4, 0, 100, 0);
    lb_on = 0;
    check("R10", "self-sync loopback drained", 64'(lb_q.size()), 64'(0));

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule